// File: doc/BRIEF.md
# Upper-Memory Bank Switch Controller

This block keeps the mode flags that decide how the top 12 KB of a 16-bit CPU address space (D000 to FFFF) is banked. There are four flags. One makes reads come from RAM instead of ROM. One lets writes land in RAM. One selects the second 4 KB RAM bank for the D000 to DFFF window. The last moves zero page and stack to alternate memory. The block watches CPU read and write strobes aimed at a few fixed I/O addresses and updates the flags from them. An address mapper beside it reads the flags to steer each memory access.

Some of the mode addresses only take effect when the previous bus access went to the same address, so the block keeps the last accessed address in a register. Three status addresses report one flag each in bit 7 of the read data. A hit output tells the system that the current access is aimed at a switch address, so the system can return the block's data instead of memory data.

Top module: `lcsw_top`

## Requirements
- R1: After reset all four flags are 0: reads come from ROM, writes are disabled, bank 1 is selected and the alternate zero page is off.
- R2: A read of C080 sets (RAM read, write enable, bank 2) to (1,0,1). C082 sets them to (0,0,1), C088 to (1,0,0) and C08A to (0,0,0). These apply on a single read.
- R3: A read of C081 sets (RAM read, write enable, bank 2) to (0,1,1), C083 to (1,1,1), C089 to (0,1,0) and C08B to (1,1,0). Each applies only when the previous valid bus access was to the same address.
- R4: A read of C081, C083, C089 or C08B leaves all flags unchanged when the previous valid access was to a different address.
- R5: A read of any mode address (C080 to C083, C088 to C08B) returns 00 on rd_data.
- R6: Reads of C011, C012 and C016 return 80 when the bank 2 flag, the RAM read flag or the alternate zero page flag is set, respectively, and 00 otherwise. They change no flag.
- R7: A write to C008 sets the alternate zero page flag and a write to C009 clears it. Flag changes show on the outputs one clock after the strobe.
- R8: Mode address reads never change the alternate zero page flag.
- R9: Every valid access, read or write, updates the previous-address register. Idle cycles do not. So a write to C083 followed by a read of C083, even with idle cycles between them, meets the repeat condition.
- R10: sw_hit is 1 during a read of a mode or status address and during a write to C008 or C009. It is 0 otherwise, and rd_data is 00 whenever no status read is under way.
- R11: Accesses to any other address, and reads of C008 or C009, leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| rd_stb | input | 1 | Read access this cycle |
| wr_stb | input | 1 | Write access this cycle |
| rd_data | output | 8 | Switch read data, combinational |
| sel_ram_rd | output | 1 | Reads of D000 to FFFF come from RAM |
| sel_wr_en | output | 1 | Writes to D000 to FFFF reach RAM |
| sel_bank2 | output | 1 | Second RAM bank in the D000 to DFFF window |
| sel_alt_zp | output | 1 | Zero page and stack in alternate memory |
| sw_hit | output | 1 | Current access targets a switch address |

## Verification
The hardest case to reach is the repeat condition. Whether a repeat switch takes effect depends on the previous valid access, not on the previous clock cycle. That previous access may be a write, or may lie several idle cycles back. The stimulus reaches this case in three ways: it separates the two reads with idle cycles, it puts the first access as a write to the same address, and it interleaves a different repeat address between two reads. A reference model of the previous address in the bench decides each expected outcome.

// File: rtl/lcsw_pkg.sv
package lcsw_pkg;

  typedef struct packed {
    logic alt_zp;
    logic bank2;
    logic wr_en;
    logic ram_rd;
  } lc_flags_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_MODE,
    CMD_STAT_BANK2,
    CMD_STAT_RAM,
    CMD_STAT_ALTZP
  } rd_cmd_e;

  // Mode nibble -> {bank2, wr_en, ram_rd}.
  // Bit 3 clear picks bank 2, bit 0 enables writes,
  // and RAM reads happen when bits 1 and 0 agree.
  function automatic logic [2:0] mode_bits(input logic [3:0] sel);
    return {~sel[3], sel[0], ~(sel[1] ^ sel[0])};
  endfunction

  // Write-enabling modes need a repeated access to the same address.
  function automatic logic needs_repeat(input logic [3:0] sel);
    return sel[0];
  endfunction

endpackage

// File: rtl/lcsw_decode.sv
module lcsw_decode
  import lcsw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_BASE   = 16'hC080,
  parameter logic [ADDR_W-1:0] STAT_BANK2  = 16'hC011,
  parameter logic [ADDR_W-1:0] STAT_RAM    = 16'hC012,
  parameter logic [ADDR_W-1:0] STAT_ALTZP  = 16'hC016,
  parameter logic [ADDR_W-1:0] ALTZP_ON    = 16'hC008,
  parameter logic [ADDR_W-1:0] ALTZP_OFF   = 16'hC009
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output rd_cmd_e           rd_cmd,
  output logic [3:0]        mode_sel,
  output logic              altzp_set,
  output logic              altzp_clr
);
  localparam int HI_W = ADDR_W - 4;

  logic mode_match;
  assign mode_match = (addr[ADDR_W-1:4] == MODE_BASE[ADDR_W-1:4]) && !addr[2];
  assign mode_sel   = addr[3:0];

  always_comb begin
    rd_cmd = CMD_NONE;
    if (rd_stb) begin
      if (mode_match)               rd_cmd = CMD_MODE;
      else if (addr == STAT_BANK2)  rd_cmd = CMD_STAT_BANK2;
      else if (addr == STAT_RAM)    rd_cmd = CMD_STAT_RAM;
      else if (addr == STAT_ALTZP)  rd_cmd = CMD_STAT_ALTZP;
    end
  end

  assign altzp_set = wr_stb && (addr == ALTZP_ON);
  assign altzp_clr = wr_stb && (addr == ALTZP_OFF);

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/lcsw_mode_reg.sv
module lcsw_mode_reg
  import lcsw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PREV_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_vld,
  input  logic [ADDR_W-1:0] addr,
  input  rd_cmd_e           rd_cmd,
  input  logic [3:0]        mode_sel,
  input  logic              altzp_set,
  input  logic              altzp_clr,
  output lc_flags_t         flags,
  output logic              repeat_ok,
  output logic              mode_apply
);
  logic [ADDR_W-1:0] prev_addr;
  logic [2:0]        next_mode;

  assign repeat_ok  = (prev_addr == addr);
  assign mode_apply = (rd_cmd == CMD_MODE) && (!needs_repeat(mode_sel) || repeat_ok);
  assign next_mode  = mode_bits(mode_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      prev_addr <= PREV_RST;
    end else begin
      if (access_vld) prev_addr <= addr;
      if (mode_apply) begin
        flags.bank2  <= next_mode[2];
        flags.wr_en  <= next_mode[1];
        flags.ram_rd <= next_mode[0];
      end
      if (altzp_set)      flags.alt_zp <= 1'b1;
      else if (altzp_clr) flags.alt_zp <= 1'b0;
    end
  end
endmodule

// File: rtl/lcsw_status.sv
module lcsw_status
  import lcsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_BIT = DATA_W - 1
) (
  input  rd_cmd_e           rd_cmd,
  input  lc_flags_t         flags,
  output logic [DATA_W-1:0] rd_data
);
  logic flag_sel;

  always_comb begin
    case (rd_cmd)
      CMD_STAT_BANK2: flag_sel = flags.bank2;
      CMD_STAT_RAM:   flag_sel = flags.ram_rd;
      CMD_STAT_ALTZP: flag_sel = flags.alt_zp;
      default:        flag_sel = 1'b0;
    endcase
    rd_data = '0;
    rd_data[STAT_BIT] = flag_sel;
  end
endmodule

// File: rtl/lcsw_top.sv
module lcsw_top
  import lcsw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              sel_ram_rd,
  output logic              sel_wr_en,
  output logic              sel_bank2,
  output logic              sel_alt_zp,
  output logic              sw_hit
);
  rd_cmd_e    rd_cmd;
  logic [3:0] mode_sel;
  logic       altzp_set;
  logic       altzp_clr;
  logic       access_vld;
  logic       repeat_ok;
  logic       mode_apply;
  lc_flags_t  flags;

  assign access_vld = rd_stb | wr_stb;

  lcsw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (cpu_addr),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .rd_cmd    (rd_cmd),
    .mode_sel  (mode_sel),
    .altzp_set (altzp_set),
    .altzp_clr (altzp_clr)
  );

  lcsw_mode_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .access_vld (access_vld),
    .addr       (cpu_addr),
    .rd_cmd     (rd_cmd),
    .mode_sel   (mode_sel),
    .altzp_set  (altzp_set),
    .altzp_clr  (altzp_clr),
    .flags      (flags),
    .repeat_ok  (repeat_ok),
    .mode_apply (mode_apply)
  );

  lcsw_status #(.DATA_W(DATA_W)) u_stat (
    .rd_cmd  (rd_cmd),
    .flags   (flags),
    .rd_data (rd_data)
  );

  assign sel_ram_rd = flags.ram_rd;
  assign sel_wr_en  = flags.wr_en;
  assign sel_bank2  = flags.bank2;
  assign sel_alt_zp = flags.alt_zp;
  assign sw_hit     = (rd_cmd != CMD_NONE) | altzp_set | altzp_clr;
endmodule

// File: rtl/lcsw_chk.sv
module lcsw_chk
  import lcsw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              sel_ram_rd,
  input logic              sel_wr_en,
  input logic              sel_bank2,
  input logic              sel_alt_zp,
  input logic              sw_hit,
  input logic              mode_apply
);
  logic [ADDR_W-1:0] seen_addr;
  logic              is_mode, is_rep, is_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_addr <= '0;
    else if (rd_stb || wr_stb) seen_addr <= cpu_addr;
  end

  assign is_mode = (cpu_addr[15:4] == 12'hC08) && !cpu_addr[2];
  assign is_rep  = is_mode && cpu_addr[0];
  assign is_stat = (cpu_addr == 16'hC011) || (cpu_addr == 16'hC012) || (cpu_addr == 16'hC016);

  // R4
  no_lone_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && is_rep && seen_addr != cpu_addr)
      |=> $stable({sel_ram_rd, sel_wr_en, sel_bank2, sel_alt_zp}));

  // R8
  altzp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && is_mode) |=> $stable(sel_alt_zp));

  // R7
  altzp_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cpu_addr == 16'hC008) |=> sel_alt_zp);

  // R7
  altzp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cpu_addr == 16'hC009) |=> !sel_alt_zp);

  // R2
  c080_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && cpu_addr == 16'hC080) |=> (sel_ram_rd && !sel_wr_en && sel_bank2));

  // R10
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && is_stat) |-> (rd_data == '0));

  // R10
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |-> !sw_hit);

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_hit) |=> $stable({sel_ram_rd, sel_wr_en, sel_bank2, sel_alt_zp}));

  // R3
  apply_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_apply |-> (rd_stb && is_mode));
endmodule

bind lcsw_top lcsw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .rd_data    (rd_data),
  .sel_ram_rd (sel_ram_rd),
  .sel_wr_en  (sel_wr_en),
  .sel_bank2  (sel_bank2),
  .sel_alt_zp (sel_alt_zp),
  .sw_hit     (sw_hit),
  .mode_apply (mode_apply)
);

// File: tb/tb_lcsw_top.sv
module tb_lcsw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        sel_ram_rd, sel_wr_en, sel_bank2, sel_alt_zp, sw_hit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state: {alt_zp, bank2, wr_en, ram_rd}
  logic [3:0]  m_flags;
  logic [15:0] m_prev;
  logic [7:0]  got_data;
  logic        got_hit;

  always #2 clk = ~clk;

  lcsw_top dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rd_data(rd_data), .sel_ram_rd(sel_ram_rd), .sel_wr_en(sel_wr_en),
    .sel_bank2(sel_bank2), .sel_alt_zp(sel_alt_zp), .sw_hit(sw_hit)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] dut_flags();
    return {sel_alt_zp, sel_bank2, sel_wr_en, sel_ram_rd};
  endfunction

  // Model update for a read, written as an explicit table.
  function automatic void model_read(input logic [15:0] a);
    logic [2:0] m;   // {bank2, wr_en, ram_rd}
    bit single, rep;
    single = 1; rep = 0; m = 3'b000;
    case (a)
      16'hC080: m = 3'b101;
      16'hC082: m = 3'b100;
      16'hC088: m = 3'b001;
      16'hC08A: m = 3'b000;
      16'hC081: begin m = 3'b110; rep = 1; end
      16'hC083: begin m = 3'b111; rep = 1; end
      16'hC089: begin m = 3'b010; rep = 1; end
      16'hC08B: begin m = 3'b011; rep = 1; end
      default: single = 0;
    endcase
    if ((single && !rep) || (rep && m_prev == a)) m_flags[2:0] = m;
    m_prev = a;
  endfunction

  function automatic logic [7:0] model_data(input logic [15:0] a);
    case (a)
      16'hC011: return m_flags[2] ? 8'h80 : 8'h00;
      16'hC012: return m_flags[0] ? 8'h80 : 8'h00;
      16'hC016: return m_flags[3] ? 8'h80 : 8'h00;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic bit model_hit_rd(input logic [15:0] a);
    return (a[15:4] == 12'hC08 && !a[2]) || a == 16'hC011 || a == 16'hC012 || a == 16'hC016;
  endfunction

  task automatic do_rd(input logic [15:0] a, input string tag);
    logic [7:0] exp_d;
    bit exp_h;
    exp_d = model_data(a);
    exp_h = model_hit_rd(a);
    @(negedge clk);
    cpu_addr = a; rd_stb = 1'b1;
    #1 got_data = rd_data; got_hit = sw_hit;
    @(negedge clk);
    rd_stb = 1'b0;
    model_read(a);
    check(got_data == exp_d, {tag, " data"}, {8'h0, got_data}, {8'h0, exp_d});
    check(got_hit == exp_h, "R10 hit", {15'h0, got_hit}, {15'h0, exp_h});
    check(dut_flags() == m_flags, {tag, " flags"}, {12'h0, dut_flags()}, {12'h0, m_flags});
  endtask

  task automatic do_wr(input logic [15:0] a, input string tag);
    bit exp_h;
    exp_h = (a == 16'hC008 || a == 16'hC009);
    @(negedge clk);
    cpu_addr = a; wr_stb = 1'b1;
    #1 got_hit = sw_hit;
    @(negedge clk);
    wr_stb = 1'b0;
    if (a == 16'hC008) m_flags[3] = 1'b1;
    if (a == 16'hC009) m_flags[3] = 1'b0;
    m_prev = a;
    check(got_hit == exp_h, "R10 hit on write", {15'h0, got_hit}, {15'h0, exp_h});
    check(dut_flags() == m_flags, {tag, " flags"}, {12'h0, dut_flags()}, {12'h0, m_flags});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cpu_addr = '0; rd_stb = 0; wr_stb = 0;
    idle(3);
    rst_n = 1'b1;
    m_flags = 4'b0000; m_prev = 16'h0000;
    @(negedge clk);
    check(dut_flags() == 4'b0000, "R1 reset flags", {12'h0, dut_flags()}, 16'h0);
    check(rd_data == 8'h00 && !sw_hit, "R10 idle outputs", {7'h0, sw_hit, rd_data}, 16'h0);
  endtask

  task automatic t_single;   // R2, R5
    do_rd(16'hC080, "R2 C080");
    do_rd(16'hC082, "R2 C082");
    do_rd(16'hC088, "R2 C088");
    do_rd(16'hC08A, "R2 C08A");
    check(dut_flags() == 4'b0000, "R2 default restored", {12'h0, dut_flags()}, 16'h0);
  endtask

  task automatic t_double;   // R3, R4
    do_rd(16'hC081, "R4 C081 first");
    do_rd(16'hC081, "R3 C081 second");
    check(dut_flags() == 4'b0110, "R3 C081 mode", {12'h0, dut_flags()}, 16'h6);
    do_rd(16'hC08A, "R2 reset mode");
    do_rd(16'hC083, "R4 C083 first");
    idle(3);
    do_rd(16'hC083, "R3 C083 after idle");
    check(dut_flags() == 4'b0111, "R3 C083 mode", {12'h0, dut_flags()}, 16'h7);
    do_rd(16'hC088, "R2 C088");
    do_rd(16'hC089, "R4 C089 first");
    do_rd(16'hC089, "R3 C089 second");
    do_rd(16'hC08B, "R4 C08B first");
    do_rd(16'hC08B, "R3 C08B second");
    check(dut_flags() == 4'b0011, "R3 C08B mode", {12'h0, dut_flags()}, 16'h3);
  endtask

  task automatic t_broken;   // R4
    do_rd(16'hC08A, "R2 default");
    do_rd(16'hC081, "R4 lone C081");
    do_rd(16'hC083, "R4 C083 after C081");
    do_rd(16'hC081, "R4 C081 after C083");
    do_wr(16'h1234, "R4 foreign write");
    do_rd(16'hC081, "R4 C081 after write");
    check(dut_flags() == 4'b0000, "R4 flags unchanged", {12'h0, dut_flags()}, 16'h0);
  endtask

  task automatic t_prev_write;   // R9
    do_wr(16'hC083, "R9 write C083");
    idle(2);
    do_rd(16'hC083, "R9 read C083 after write");
    check(dut_flags() == 4'b0111, "R9 write counts as previous", {12'h0, dut_flags()}, 16'h7);
  endtask

  task automatic t_status;   // R6
    do_rd(16'hC011, "R6 bank2 status on");
    do_rd(16'hC012, "R6 ram status on");
    do_rd(16'hC016, "R6 altzp status off");
    do_rd(16'hC08A, "R2 default");
    do_rd(16'hC011, "R6 bank2 status off");
    do_rd(16'hC012, "R6 ram status off");
    do_wr(16'hC008, "R7 set altzp");
    do_rd(16'hC016, "R6 altzp status on");
  endtask

  task automatic t_altzp;   // R7, R8
    do_wr(16'hC008, "R7 set altzp");
    do_rd(16'hC080, "R8 C080 keeps altzp");
    do_rd(16'hC08B, "R8 C08B first keeps altzp");
    do_rd(16'hC08B, "R8 C08B second keeps altzp");
    check(sel_alt_zp == 1'b1, "R8 altzp held", {15'h0, sel_alt_zp}, 16'h1);
    do_wr(16'hC009, "R7 clear altzp");
    check(sel_alt_zp == 1'b0, "R7 altzp cleared", {15'h0, sel_alt_zp}, 16'h0);
  endtask

  task automatic t_other;   // R11
    do_rd(16'hC080, "R2 C080");
    do_rd(16'hC008, "R11 read C008");
    do_rd(16'hC084, "R11 read C084");
    do_rd(16'hD000, "R11 read D000");
    do_wr(16'hC080, "R11 write C080");
    do_wr(16'hC011, "R11 write C011");
    check(dut_flags() == 4'b0101, "R11 flags untouched", {12'h0, dut_flags()}, 16'h5);
  endtask

  initial begin
    t_reset();
    t_single();
    t_double();
    t_broken();
    t_prev_write();
    t_status();
    t_altzp();
    t_other();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule